// File: doc/BRIEF.md
# Indexed Operand Address Generator

This block forms the effective memory address of an indexed operand for a microcontroller whose registers and addresses are 20 bits wide. It adds a signed displacement from the instruction to a base register value. The base register value and displacement are inputs. An instruction-class flag selects the sign position of the displacement. For older-style instructions a compatibility rule folds the sum back into the lower 64 KiB.

In post-increment mode the block also returns the base register's new value and a write-back strobe. The new value is the base advanced by the operand size in bytes. If the base is the stack pointer, the new value is kept on an even address. Decode, the register file and memory are outside the block. A parameter chooses between a purely combinational path and one output register stage.

Top module: `opnd_addr_gen`

## Requirements
- R1: When `base_used` is low, `addr` equals `index_val` unchanged, whatever the base value or instruction class.
- R2: With `ext_insn` low, the displacement is `index_val[15:0]` sign-extended from bit 15. Bits 19:16 of `index_val` have no effect.
- R3: With `ext_insn` high, the displacement is the full 20-bit `index_val` (sign at bit 19), and the sum wraps modulo 2^20.
- R4: With `ext_insn` low, `base_used` high and `base_val` below 0x10000, `addr` is the sum truncated to 16 bits (bits 19:16 read zero).
- R5: With `ext_insn` low and `base_val` at or above 0x10000, `addr` is the full 20-bit sum with no 16-bit truncation.
- R6: `wb_val` is `base_val` plus a size step, taken modulo 2^20. The step is selected by `size_sel`: 0 gives 1 (byte), 1 gives 2 (word), and 2 or 3 give 4 (32-bit).
- R7: When `base_is_sp` is high and `base_val` plus the step is odd, `wb_val` is that sum plus one, so the stack pointer stays even.
- R8: `wb_en` is high exactly when `mode` is 1 (post-increment) and `base_used` is high. Mode 0 (plain indirect) never asserts it.
- R9: With `OUT_REG`=1, the outputs follow the inputs one clock later, and a synchronous active-low reset clears `addr`, `wb_en` and `wb_val` to zero. With `OUT_REG`=0, the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Synchronous active-low reset |
| base_val | input | 20 | Current value of the base register |
| index_val | input | 20 | Displacement, or absolute address when no base is used |
| base_used | input | 1 | High when a base register takes part |
| base_is_sp | input | 1 | High when the base register is the stack pointer |
| ext_insn | input | 1 | High for an extended (20-bit) instruction |
| size_sel | input | 2 | Operand size: 0 byte, 1 word, 2/3 32-bit |
| mode | input | 1 | 0 indirect, 1 indirect with post-increment |
| addr | output | 20 | Effective address |
| wb_en | output | 1 | Base register write-back strobe |
| wb_val | output | 20 | Updated base register value |

## Verification
The bench builds two copies of the block, both with the default 20-bit address and 16-bit legacy widths. One copy has `OUT_REG`=1 and the other `OUT_REG`=0, so both generate branches run against the same stimulus. The registered copy's one-cycle latency and reset clearing are checked against the unregistered copy's same-cycle result. The full 20-bit width allows tests at both wrap points, 0xFFFF for the legacy fold and 0xFFFFF for the extended sum and for post-increment, and on both sides of the 0x10000 base threshold.

// File: rtl/oag_pkg.sv
// Shared encodings for the operand address generator.
// Assumes a size code of 3 is treated the same as a 32-bit access.
package oag_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'd0,
        SZ_WORD     = 2'd1,
        SZ_LONG     = 2'd2,
        SZ_LONG_ALT = 2'd3
    } opsize_e;

    typedef enum logic {
        MODE_IND     = 1'b0,
        MODE_POSTINC = 1'b1
    } amode_e;

    localparam int STEP_W = 3;

    // Byte count advanced by a post-increment for a given size code.
    function automatic logic [STEP_W-1:0] step_bytes(input opsize_e sz);
        case (sz)
            SZ_BYTE: step_bytes = 3'd1;
            SZ_WORD: step_bytes = 3'd2;
            default: step_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/oag_addr_sum.sv
// Effective-address adder.
// Sign-extends the displacement from the legacy sign bit, or takes it at
// full width for extended instructions, then adds the base. A legacy
// instruction whose base lies in the low 64 KiB gets a 16-bit result.
// Without a base, the displacement is the address itself.
// Assumes AW > LW.
module oag_addr_sum #(
    parameter int AW = 20,
    parameter int LW = 16
) (
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] index_val,
    input  logic          base_used,
    input  logic          ext_insn,
    output logic [AW-1:0] addr
);
    localparam int PAD = AW - LW;

    logic [AW-1:0] idx_se;
    logic [AW-1:0] sum;
    logic          low_base;

    // Pick the sign position of the displacement by instruction class.
    always_comb begin
        if (ext_insn) idx_se = index_val;
        else          idx_se = {{PAD{index_val[LW-1]}}, index_val[LW-1:0]};
    end

    assign sum      = base_val + idx_se;
    assign low_base = (base_val[AW-1:LW] == '0);

    // Choose absolute, folded-legacy or full-width result.
    always_comb begin
        if (!base_used)                 addr = index_val;
        else if (!ext_insn && low_base) addr = {{PAD{1'b0}}, sum[LW-1:0]};
        else                            addr = sum;
    end

endmodule

// File: rtl/oag_post_inc.sv
// Post-increment value generator.
// Advances the base by the operand byte count, modulo 2^AW. If the base is
// the stack pointer and the result is odd, one more is added so that it
// stays even.
module oag_post_inc #(
    parameter int AW = 20
) (
    input  logic [AW-1:0] base_val,
    input  logic [1:0]    size_sel,
    input  logic          base_is_sp,
    output logic [AW-1:0] next_val
);
    import oag_pkg::*;

    logic [STEP_W-1:0] step;
    logic [AW-1:0]     raw;

    // Decode the size code into a byte step.
    always_comb step = step_bytes(opsize_e'(size_sel));

    assign raw      = base_val + {{(AW-STEP_W){1'b0}}, step};
    assign next_val = (base_is_sp && raw[0]) ? raw + {{(AW-1){1'b0}}, 1'b1} : raw;

endmodule

// File: rtl/opnd_addr_gen.sv
// Indexed operand address generator (top).
// Combines the address adder and the post-increment generator. Write-back
// is requested only for post-increment with a base register. OUT_REG
// selects one output register stage (1) or a combinational path (0).
// The registered stage has a synchronous active-low reset.
module opnd_addr_gen #(
    parameter int AW      = 20,
    parameter int LW      = 16,
    parameter bit OUT_REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] index_val,
    input  logic          base_used,
    input  logic          base_is_sp,
    input  logic          ext_insn,
    input  logic [1:0]    size_sel,
    input  logic          mode,
    output logic [AW-1:0] addr,
    output logic          wb_en,
    output logic [AW-1:0] wb_val
);
    import oag_pkg::*;

    logic [AW-1:0] addr_c;
    logic [AW-1:0] inc_c;
    logic          wb_c;

    oag_addr_sum #(.AW(AW), .LW(LW)) u_sum (
        .base_val  (base_val),
        .index_val (index_val),
        .base_used (base_used),
        .ext_insn  (ext_insn),
        .addr      (addr_c)
    );

    oag_post_inc #(.AW(AW)) u_inc (
        .base_val   (base_val),
        .size_sel   (size_sel),
        .base_is_sp (base_is_sp),
        .next_val   (inc_c)
    );

    assign wb_c = (amode_e'(mode) == MODE_POSTINC) && base_used;

    generate
        if (OUT_REG) begin : g_reg
            // Output stage: capture results, clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    addr   <= '0;
                    wb_en  <= 1'b0;
                    wb_val <= '0;
                end else begin
                    addr   <= addr_c;
                    wb_en  <= wb_c;
                    wb_val <= inc_c;
                end
            end
        end else begin : g_comb
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst_n;
            assign addr   = addr_c;
            assign wb_en  = wb_c;
            assign wb_val = inc_c;
        end
    endgenerate

endmodule

// File: rtl/opnd_addr_gen_chk.sv
// Property checker for opnd_addr_gen, attached with bind.
// Output checks are taken against the inputs of the same cycle, or of
// the previous cycle when the output stage is present.
module opnd_addr_gen_chk #(
    parameter int AW      = 20,
    parameter int LW      = 16,
    parameter bit OUT_REG = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] base_val,
    input logic [AW-1:0] index_val,
    input logic          base_used,
    input logic          base_is_sp,
    input logic          ext_insn,
    input logic [1:0]    size_sel,
    input logic          mode,
    input logic [AW-1:0] addr,
    input logic          wb_en,
    input logic [AW-1:0] wb_val
);
    // Byte step for a size code.
    function automatic logic [AW-1:0] chk_step(input logic [1:0] s);
        chk_step = (s == 2'd0) ? AW'(1) : (s == 2'd1) ? AW'(2) : AW'(4);
    endfunction

    generate
        if (OUT_REG) begin : g_seq
            p_no_base_r1: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && !$past(base_used)) |-> (addr == $past(index_val)));
            p_legacy_fold_r4: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(base_used) && !$past(ext_insn)
                 && ($past(base_val) < (AW'(1) << LW))) |-> (addr[AW-1:LW] == '0));
            p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && !$past(base_is_sp))
                |-> (wb_val == $past(base_val) + chk_step($past(size_sel))));
            p_sp_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(base_is_sp)) |-> !wb_val[0]);
            p_wb_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (wb_en == ($past(mode) && $past(base_used))));
        end else begin : g_cmb
            p_no_base_r1: assert property (@(posedge clk) disable iff (!rst_n)
                !base_used |-> (addr == index_val));
            p_legacy_fold_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (base_used && !ext_insn && (base_val < (AW'(1) << LW)))
                |-> (addr[AW-1:LW] == '0));
            p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !base_is_sp |-> (wb_val == base_val + chk_step(size_sel)));
            p_sp_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
                base_is_sp |-> !wb_val[0]);
            p_wb_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
                wb_en == (mode && base_used));
        end
    endgenerate

endmodule

bind opnd_addr_gen opnd_addr_gen_chk #(.AW(AW), .LW(LW), .OUT_REG(OUT_REG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_val   (base_val),
    .index_val  (index_val),
    .base_used  (base_used),
    .base_is_sp (base_is_sp),
    .ext_insn   (ext_insn),
    .size_sel   (size_sel),
    .mode       (mode),
    .addr       (addr),
    .wb_en      (wb_en),
    .wb_val     (wb_val)
);

// File: tb/tb_opnd_addr_gen.sv
module tb_opnd_addr_gen;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;
    localparam int WATCHDOG = 5000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] base_val = '0, index_val = '0;
    logic          base_used = 1'b0, base_is_sp = 1'b0, ext_insn = 1'b0, mode = 1'b0;
    logic [1:0]    size_sel = 2'd0;
    logic [AW-1:0] addr_r, wbv_r, addr_c, wbv_c;
    logic          wbe_r, wbe_c;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opnd_addr_gen #(.AW(AW), .LW(16), .OUT_REG(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .base_val(base_val), .index_val(index_val),
        .base_used(base_used), .base_is_sp(base_is_sp), .ext_insn(ext_insn),
        .size_sel(size_sel), .mode(mode), .addr(addr_r), .wb_en(wbe_r), .wb_val(wbv_r));

    opnd_addr_gen #(.AW(AW), .LW(16), .OUT_REG(1'b0)) dut_c (
        .clk(clk), .rst_n(rst_n), .base_val(base_val), .index_val(index_val),
        .base_used(base_used), .base_is_sp(base_is_sp), .ext_insn(ext_insn),
        .size_sel(size_sel), .mode(mode), .addr(addr_c), .wb_en(wbe_c), .wb_val(wbv_c));

    task automatic chk(input string req, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive at a falling edge (caller is already there).
    task automatic drive(input logic [AW-1:0] b, input logic [AW-1:0] idx, input logic used,
                         input logic sp, input logic ext, input logic [1:0] sz, input logic md);
        base_val = b; index_val = idx; base_used = used; base_is_sp = sp;
        ext_insn = ext; size_sel = sz; mode = md;
    endtask

    // Check the combinational copy now, the registered copy one edge later.
    task automatic expect_out(input string req, input logic [AW-1:0] ea, input logic ee, input logic [AW-1:0] ew);
        #1;
        chk(req, "comb addr", addr_c, ea);
        chk({req, " R8"}, "comb wb_en", {{(AW-1){1'b0}}, wbe_c}, {{(AW-1){1'b0}}, ee});
        if (ee) chk(req, "comb wb_val", wbv_c, ew);
        @(posedge clk); @(negedge clk);
        chk({req, " R9"}, "reg addr", addr_r, ea);
        chk({req, " R9"}, "reg wb_en", {{(AW-1){1'b0}}, wbe_r}, {{(AW-1){1'b0}}, ee});
        if (ee) chk({req, " R9"}, "reg wb_val", wbv_r, ew);
    endtask

    task automatic t_reset_r9;
        drive(20'h12345, 20'h00011, 1'b1, 1'b0, 1'b1, 2'd1, 1'b1);
        @(posedge clk); @(negedge clk);
        chk("R9", "reset addr", addr_r, '0);
        chk("R9", "reset wb_en", {{(AW-1){1'b0}}, wbe_r}, '0);
        chk("R9", "reset wb_val", wbv_r, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_absolute_r1;
        drive(20'h0FFF0, 20'h12345, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0);
        expect_out("R1", 20'h12345, 1'b0, '0);
        drive(20'hAAAAA, 20'hF0001, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0);
        expect_out("R1", 20'hF0001, 1'b0, '0);
    endtask

    task automatic t_legacy_index_r2;
        drive(20'h00200, 20'h00010, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0);
        expect_out("R2", 20'h00210, 1'b0, '0);
        drive(20'h00200, 20'hAFFFE, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0);
        expect_out("R2", 20'h001FE, 1'b0, '0);
    endtask

    task automatic t_ext_r3;
        drive(20'h0FFF0, 20'h00020, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0);
        expect_out("R3", 20'h10010, 1'b0, '0);
        drive(20'h00000, 20'hFFFFF, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0);
        expect_out("R3", 20'hFFFFF, 1'b0, '0);
        drive(20'hFFFF0, 20'h00020, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0);
        expect_out("R3", 20'h00010, 1'b0, '0);
    endtask

    task automatic t_legacy_fold_r4;
        drive(20'h0FFF0, 20'h00020, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0);
        expect_out("R4", 20'h00010, 1'b0, '0);
        drive(20'h00010, 20'h0FFE0, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0);
        expect_out("R4", 20'h0FFF0, 1'b0, '0);
    endtask

    task automatic t_legacy_high_r5;
        drive(20'h1FFF0, 20'h00020, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0);
        expect_out("R5", 20'h20010, 1'b0, '0);
        drive(20'h10000, 20'h0FFFF, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0);
        expect_out("R5", 20'h0FFFF, 1'b0, '0);
    endtask

    task automatic t_sizes_r6;
        drive(20'h00300, 20'h00000, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1);
        expect_out("R6", 20'h00300, 1'b1, 20'h00301);
        drive(20'h00300, 20'h00000, 1'b1, 1'b0, 1'b0, 2'd1, 1'b1);
        expect_out("R6", 20'h00300, 1'b1, 20'h00302);
        drive(20'h00300, 20'h00000, 1'b1, 1'b0, 1'b0, 2'd2, 1'b1);
        expect_out("R6", 20'h00300, 1'b1, 20'h00304);
        drive(20'h00301, 20'h00000, 1'b1, 1'b0, 1'b0, 2'd3, 1'b1);
        expect_out("R6", 20'h00301, 1'b1, 20'h00305);
        drive(20'hFFFFF, 20'h00000, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1);
        expect_out("R6", 20'hFFFFF, 1'b1, 20'h00000);
    endtask

    task automatic t_sp_even_r7;
        drive(20'h00400, 20'h00000, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1);
        expect_out("R7", 20'h00400, 1'b1, 20'h00402);
        drive(20'h00401, 20'h00000, 1'b1, 1'b1, 1'b0, 2'd1, 1'b1);
        expect_out("R7", 20'h00401, 1'b1, 20'h00404);
        drive(20'h00402, 20'h00000, 1'b1, 1'b1, 1'b0, 2'd2, 1'b1);
        expect_out("R7", 20'h00402, 1'b1, 20'h00406);
        drive(20'hFFFFE, 20'h00000, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1);
        expect_out("R7", 20'hFFFFE, 1'b1, 20'h00000);
    endtask

    task automatic t_wb_gate_r8;
        drive(20'h00600, 20'h00500, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1);
        expect_out("R8", 20'h00500, 1'b0, '0);
        drive(20'h00600, 20'h00000, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0);
        expect_out("R8", 20'h00600, 1'b0, '0);
    endtask

    initial begin
        @(negedge clk);
        t_reset_r9();
        t_absolute_r1();
        t_legacy_index_r2();
        t_ext_r3();
        t_legacy_fold_r4();
        t_legacy_high_r5();
        t_sizes_r6();
        t_sp_even_r7();
        t_wb_gate_r8();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule